// File: doc/BRIEF.md
# ADB host transaction sequencer

This block runs host-side Apple Desktop Bus transactions through an external bus transceiver. The transceiver is reached through a byte shifter whose direction the block selects, a two-bit state code that the block drives to frame each byte, one active-low status line that the transceiver drives, and a single-cycle byte-done strobe that marks each finished byte. The bus analog layer and all bit timing stay inside the transceiver.

A caller offers one request at a time: a command byte, 1 to 13 payload bytes and a flag that says whether a reply is wanted. The sequencer shifts the bytes out, turns the shifter around when a reply follows, and collects reply bytes into a 16-entry buffer that has a registered read port. Each finished request and each reply that the caller did not ask for produces a one-cycle report with a length, a timeout flag, a service-request flag and an error flag. A reply that the transceiver had buffered from autopolling can appear in place of the command. It is reported as unsolicited, and the interrupted request is then sent again.

Top module: `adb_host_seq`

## Requirements
- R1: After reset, and whenever the sequencer settles with no request held, the state code is idle (2'b11), the shifter is set to input and req_ready is 1.
- R2: An accepted valid request loads its command byte into the shifter with one sh_load pulse, sets the shifter to output and drives the command state code 2'b00.
- R3: The first byte-done in the command state moves the state code to even (2'b01). Every later byte flips both bits, so even and odd (2'b10) alternate, and the payload bytes go out in order, one per byte-done.
- R4: A byte-done with the status line low in the command state turns the shifter to input and starts an unsolicited reply whose byte 0 is the most recent command sent with bits 3:2 = 2'b11. When that reply ends the request is sent again from its command byte.
- R5: Once the last payload byte is done, a request with the reply flag set reads a solicited reply whose byte 0 is the command. A command with bits 3:2 = 2'b11 and no reply flag completes at once (report length 0) and its reply is read as unsolicited. Any other request completes and the sequencer goes idle.
- R6: While reading, status low in the even state with one byte held sets the timeout flag, and the reply is then reported with length 0.
- R7: While reading, status low in the odd state with two bytes held sets the service-request flag of that reply's report.
- R8: While reading, status low at any other point ends the reply. The report carries the number of bytes held, byte 0 included, and the bytes can be read back at buffer addresses 0 and up.
- R9: Reply bytes beyond the 16th are dropped and the count stays at 16, but each still flips the state code.
- R10: In idle, a byte-done with the status line low stores the received byte as reply byte 0, sets the state code to even and starts an unsolicited reply.
- R11: In idle, a byte-done with the status line high gives an unsolicited report with the timeout flag set and length 0, and the state code stays idle.
- R12: A request with 0 or more than 13 payload bytes completes at once with done_err set and length 0, and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered (single-cycle) |
| req_cmd | input | 8 | Command byte |
| req_len | input | 4 | Payload byte count |
| req_payload | input | 104 | Payload bytes, byte 0 in bits 7:0 |
| req_want_reply | input | 1 | Caller wants the reply |
| req_ready | output | 1 | Sequencer can accept a request |
| sh_out_en | output | 1 | Shifter direction, 1 = output |
| sh_tx_byte | output | 8 | Byte loaded into the shifter |
| sh_load | output | 1 | Pulse: sh_tx_byte is new |
| sh_rx_byte | input | 8 | Byte received by the shifter |
| byte_done | input | 1 | Byte finished strobe |
| xcvr_stat_n | input | 1 | Transceiver status, active low |
| bus_state | output | 2 | Framing state code |
| done | output | 1 | Report pulse |
| done_err | output | 1 | Request rejected |
| done_unsol | output | 1 | Report is for an unsolicited reply |
| done_tmo | output | 1 | Timeout seen |
| done_srq | output | 1 | Service request seen |
| done_len | output | 5 | Reply length |
| rd_addr | input | 4 | Reply buffer read address |
| rd_data | output | 8 | Reply byte, one cycle after rd_addr |

## Verification
A wrong phase or state register shows at bus_state and sh_out_en on the very next byte-done: the even/odd pattern breaks, the shifter faces the wrong way, or the code fails to return to 2'b11. Misrouted byte-0 sources, a lost count or a wrong flag decode show in the report pulse that ends the reply and in the buffered bytes read back right after it. Each stimulus step is followed by a port-level comparison, so a fault is reported within one byte of its cause.

// File: rtl/adbh_pkg.sv
package adbh_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] ST_CMD  = 2'b00;
  localparam logic [1:0] ST_EVEN = 2'b01;
  localparam logic [1:0] ST_ODD  = 2'b10;
  localparam logic [1:0] ST_IDLE = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_READ = 2'd2
  } phase_e;

  // Talk commands carry 2'b11 in bits 3:2
  function automatic logic is_talk(input logic [BYTE_W-1:0] c);
    return c[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/adbh_req_hold.sv
module adbh_req_hold
  import adbh_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 13,
  parameter int unsigned LEN_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap,
  input  logic [BYTE_W-1:0]             cmd_in,
  input  logic [LEN_W-1:0]              len_in,
  input  logic [MAX_PAYLOAD*BYTE_W-1:0] data_in,
  input  logic                          rexp_in,
  input  logic [LEN_W-1:0]              sel,
  output logic [BYTE_W-1:0]             cmd,
  output logic [LEN_W-1:0]              len,
  output logic                          rexp,
  output logic [BYTE_W-1:0]             sel_byte
);
  logic [BYTE_W-1:0] pay_q [MAX_PAYLOAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      len  <= '0;
      rexp <= 1'b0;
    end else if (cap) begin
      cmd  <= cmd_in;
      len  <= len_in;
      rexp <= rexp_in;
    end
  end

  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_pay
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pay_q[g] <= '0;
      end else if (cap) begin
        pay_q[g] <= data_in[g*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < MAX_PAYLOAD; i++) begin
      if (sel == LEN_W'(i)) sel_byte = pay_q[i];
    end
  end
endmodule

// File: rtl/adbh_reply_buf.sv
module adbh_reply_buf
  import adbh_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_we,
  input  logic              push_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic              room;

  assign room = count < CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (first_we) begin
      count <= CNT_W'(1);
    end else if (push_we && room) begin
      count <= count + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk) begin
      if (first_we && g == 0) begin
        mem_q[g] <= wdata;
      end else if (!first_we && push_we && room && count == CNT_W'(g)) begin
        mem_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= mem_q[rd_addr];
    end
  end
endmodule

// File: rtl/adbh_ctrl.sv
module adbh_ctrl
  import adbh_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 13,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_cmd_in,
  input  logic [LEN_W-1:0]  req_len_in,
  input  logic              byte_done,
  input  logic              stat_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] h_cmd,
  input  logic [LEN_W-1:0]  h_len,
  input  logic              h_rexp,
  input  logic [BYTE_W-1:0] h_byte,
  input  logic [CNT_W-1:0]  rcount,
  output logic              hold_cap,
  output logic [LEN_W-1:0]  idx,
  output logic              buf_first,
  output logic              buf_push,
  output logic [BYTE_W-1:0] buf_wdata,
  output logic [1:0]        bus_state,
  output logic              sh_out_en,
  output logic [BYTE_W-1:0] sh_tx_byte,
  output logic              sh_load,
  output logic              req_ready,
  output logic              done,
  output logic              done_err,
  output logic              done_unsol,
  output logic              done_tmo,
  output logic              done_srq,
  output logic [CNT_W-1:0]  done_len
);
  phase_e            ph_q, ph_d;
  logic [1:0]        st_d;
  logic              oe_d, ld_d;
  logic [BYTE_W-1:0] tx_d, talk_q, talk_d;
  logic [LEN_W-1:0]  idx_d;
  logic              held_q, held_d, sol_q, sol_d, tmo_q, tmo_d, srq_q, srq_d;
  logic              rdy_d, dn_d, err_d, uns_d, dtmo_d, dsrq_d;
  logic [CNT_W-1:0]  dlen_d;
  logic [1:0]        st_step;

  // CMD goes to EVEN, EVEN and ODD swap
  assign st_step = (bus_state == ST_CMD) ? ST_EVEN : ~bus_state;

  always_comb begin
    ph_d = ph_q;   st_d = bus_state; oe_d = sh_out_en; tx_d = sh_tx_byte;
    ld_d = 1'b0;   idx_d = idx;      held_d = held_q;  sol_d = sol_q;
    tmo_d = tmo_q; srq_d = srq_q;    talk_d = talk_q;
    dn_d = 1'b0;   err_d = done_err; uns_d = done_unsol;
    dtmo_d = done_tmo; dsrq_d = done_srq; dlen_d = done_len;
    hold_cap = 1'b0; buf_first = 1'b0; buf_push = 1'b0; buf_wdata = rx_byte;

    unique case (ph_q)
      PH_IDLE: begin
        if (byte_done) begin
          if (!stat_n) begin
            buf_first = 1'b1;
            ph_d = PH_READ; st_d = ST_EVEN; sol_d = 1'b0; tmo_d = 1'b0; srq_d = 1'b0;
          end else begin
            dn_d = 1'b1; err_d = 1'b0; uns_d = 1'b1; dtmo_d = 1'b1; dsrq_d = 1'b0;
            dlen_d = '0;
          end
        end else if (req_valid && req_ready) begin
          if (req_len_in == '0 || req_len_in > LEN_W'(MAX_PAYLOAD)) begin
            dn_d = 1'b1; err_d = 1'b1; uns_d = 1'b0; dtmo_d = 1'b0; dsrq_d = 1'b0;
            dlen_d = '0;
          end else begin
            hold_cap = 1'b1;
            ph_d = PH_SEND; st_d = ST_CMD; oe_d = 1'b1; tx_d = req_cmd_in; ld_d = 1'b1;
            idx_d = '0; held_d = 1'b1;
          end
        end
      end
      PH_SEND: begin
        if (byte_done) begin
          if (bus_state == ST_CMD && !stat_n) begin
            // buffered autopoll reply: first byte was lost on the way out
            buf_first = 1'b1; buf_wdata = talk_q;
            ph_d = PH_READ; st_d = ST_EVEN; oe_d = 1'b0;
            sol_d = 1'b0; tmo_d = 1'b0; srq_d = 1'b0;
          end else begin
            if (bus_state == ST_CMD && is_talk(h_cmd)) talk_d = h_cmd;
            st_d = st_step;
            if (idx == h_len) begin
              if (h_rexp || is_talk(h_cmd)) begin
                buf_first = 1'b1; buf_wdata = h_cmd;
                ph_d = PH_READ; oe_d = 1'b0; sol_d = h_rexp;
                tmo_d = 1'b0; srq_d = 1'b0;
              end else begin
                ph_d = PH_IDLE; st_d = ST_IDLE; oe_d = 1'b0;
              end
              if (!h_rexp) begin
                held_d = 1'b0;
                dn_d = 1'b1; err_d = 1'b0; uns_d = 1'b0; dtmo_d = 1'b0; dsrq_d = 1'b0;
                dlen_d = '0;
              end
            end else begin
              tx_d = h_byte; ld_d = 1'b1; idx_d = idx + LEN_W'(1);
            end
          end
        end
      end
      PH_READ: begin
        if (byte_done) begin
          if (!stat_n && bus_state == ST_EVEN && rcount == CNT_W'(1)) begin
            tmo_d = 1'b1; buf_push = 1'b1; st_d = st_step;
          end else if (!stat_n && bus_state == ST_ODD && rcount == CNT_W'(2)) begin
            srq_d = 1'b1; buf_push = 1'b1; st_d = st_step;
          end else if (!stat_n) begin
            dn_d = 1'b1; err_d = 1'b0; uns_d = !sol_q; dtmo_d = tmo_q; dsrq_d = srq_q;
            dlen_d = tmo_q ? '0 : rcount;
            if (sol_q) held_d = 1'b0;
            if (held_q && !sol_q) begin
              ph_d = PH_SEND; st_d = ST_CMD; oe_d = 1'b1; tx_d = h_cmd; ld_d = 1'b1;
              idx_d = '0;
            end else begin
              ph_d = PH_IDLE; st_d = ST_IDLE; oe_d = 1'b0;
            end
          end else begin
            buf_push = 1'b1; st_d = st_step;
          end
        end
      end
      default: begin
        ph_d = PH_IDLE; st_d = ST_IDLE; oe_d = 1'b0;
      end
    endcase

    rdy_d = (ph_d == PH_IDLE) && !held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;     bus_state <= ST_IDLE; sh_out_en <= 1'b0; sh_tx_byte <= '0;
      sh_load <= 1'b0;     idx <= '0;            held_q <= 1'b0;    sol_q <= 1'b0;
      tmo_q <= 1'b0;       srq_q <= 1'b0;        talk_q <= '0;      req_ready <= 1'b1;
      done <= 1'b0;        done_err <= 1'b0;     done_unsol <= 1'b0;
      done_tmo <= 1'b0;    done_srq <= 1'b0;     done_len <= '0;
    end else begin
      ph_q <= ph_d;        bus_state <= st_d;    sh_out_en <= oe_d; sh_tx_byte <= tx_d;
      sh_load <= ld_d;     idx <= idx_d;         held_q <= held_d;  sol_q <= sol_d;
      tmo_q <= tmo_d;      srq_q <= srq_d;       talk_q <= talk_d;  req_ready <= rdy_d;
      done <= dn_d;        done_err <= err_d;    done_unsol <= uns_d;
      done_tmo <= dtmo_d;  done_srq <= dsrq_d;   done_len <= dlen_d;
    end
  end
endmodule

// File: rtl/adb_host_seq.sv
module adb_host_seq
  import adbh_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 13,
  parameter int unsigned BUF_DEPTH = 16,
  localparam int unsigned LEN_W = $clog2(MAX_PAYLOAD + 1),
  localparam int unsigned ADDR_W = $clog2(BUF_DEPTH),
  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int unsigned PAY_W = MAX_PAYLOAD * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [PAY_W-1:0]  req_payload,
  input  logic              req_want_reply,
  output logic              req_ready,
  output logic              sh_out_en,
  output logic [BYTE_W-1:0] sh_tx_byte,
  output logic              sh_load,
  input  logic [BYTE_W-1:0] sh_rx_byte,
  input  logic              byte_done,
  input  logic              xcvr_stat_n,
  output logic [1:0]        bus_state,
  output logic              done,
  output logic              done_err,
  output logic              done_unsol,
  output logic              done_tmo,
  output logic              done_srq,
  output logic [CNT_W-1:0]  done_len,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic              hold_cap, h_rexp, buf_first, buf_push;
  logic [BYTE_W-1:0] h_cmd, h_byte, buf_wdata;
  logic [LEN_W-1:0]  h_len, idx;
  logic [CNT_W-1:0]  rcount;

  adbh_req_hold #(.MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(hold_cap), .cmd_in(req_cmd), .len_in(req_len),
    .data_in(req_payload), .rexp_in(req_want_reply), .sel(idx),
    .cmd(h_cmd), .len(h_len), .rexp(h_rexp), .sel_byte(h_byte)
  );

  adbh_reply_buf #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .first_we(buf_first), .push_we(buf_push),
    .wdata(buf_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .count(rcount)
  );

  adbh_ctrl #(.MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd_in(req_cmd),
    .req_len_in(req_len), .byte_done(byte_done), .stat_n(xcvr_stat_n),
    .rx_byte(sh_rx_byte), .h_cmd(h_cmd), .h_len(h_len), .h_rexp(h_rexp),
    .h_byte(h_byte), .rcount(rcount), .hold_cap(hold_cap), .idx(idx),
    .buf_first(buf_first), .buf_push(buf_push), .buf_wdata(buf_wdata),
    .bus_state(bus_state), .sh_out_en(sh_out_en), .sh_tx_byte(sh_tx_byte),
    .sh_load(sh_load), .req_ready(req_ready), .done(done), .done_err(done_err),
    .done_unsol(done_unsol), .done_tmo(done_tmo), .done_srq(done_srq),
    .done_len(done_len)
  );
endmodule

// File: rtl/adbh_checks.sv
module adbh_checks #(
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_done,
  input logic [1:0]       bus_state,
  input logic             sh_out_en,
  input logic             req_ready,
  input logic             done,
  input logic             done_err,
  input logic             done_unsol,
  input logic             done_tmo,
  input logic [CNT_W-1:0] done_len
);
  assert_idle_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'b11 |-> !sh_out_en);

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_state == 2'b11);

  assert_cmd_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'b00 |-> sh_out_en);

  assert_cmd_to_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && bus_state == 2'b00) |=> bus_state == 2'b01);

  assert_even_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && bus_state == 2'b01) |=> bus_state != 2'b01);

  assert_odd_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && bus_state == 2'b10) |=> bus_state != 2'b10);

  assert_tmo_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_tmo) |-> done_len == '0);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_len <= CNT_W'(BUF_DEPTH));

  assert_err_report_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (done_len == '0 && !done_unsol));
endmodule

bind adb_host_seq adbh_checks #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .bus_state(bus_state),
  .sh_out_en(sh_out_en), .req_ready(req_ready), .done(done), .done_err(done_err),
  .done_unsol(done_unsol), .done_tmo(done_tmo), .done_len(done_len)
);

// File: tb/sim_adb_host_seq.sv
module sim_adb_host_seq;
  localparam int unsigned NPAY = 13;

  logic             clk, rst_n;
  logic             req_valid, req_want_reply, req_ready;
  logic [7:0]       req_cmd;
  logic [3:0]       req_len;
  logic [NPAY*8-1:0] req_payload;
  logic             sh_out_en, sh_load, byte_done, xcvr_stat_n;
  logic [7:0]       sh_tx_byte, sh_rx_byte, rd_data;
  logic [1:0]       bus_state;
  logic             done, done_err, done_unsol, done_tmo, done_srq;
  logic [4:0]       done_len;
  logic [3:0]       rd_addr;

  int n_chk, n_fail;
  bit finished;

  typedef struct packed {
    logic       err;
    logic       unsol;
    logic       tmo;
    logic       srq;
    logic [4:0] len;
  } rpt_t;
  rpt_t exp_q[$];

  adb_host_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_len(req_len), .req_payload(req_payload), .req_want_reply(req_want_reply),
    .req_ready(req_ready), .sh_out_en(sh_out_en), .sh_tx_byte(sh_tx_byte),
    .sh_load(sh_load), .sh_rx_byte(sh_rx_byte), .byte_done(byte_done),
    .xcvr_stat_n(xcvr_stat_n), .bus_state(bus_state), .done(done),
    .done_err(done_err), .done_unsol(done_unsol), .done_tmo(done_tmo),
    .done_srq(done_srq), .done_len(done_len), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rpt(input logic e, input logic u, input logic t,
                            input logic s, input logic [4:0] l);
    rpt_t r;
    r.err = e; r.unsol = u; r.tmo = t; r.srq = s; r.len = l;
    exp_q.push_back(r);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      rpt_t a;
      a.err = done_err; a.unsol = done_unsol; a.tmo = done_tmo;
      a.srq = done_srq; a.len = done_len;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R8 unexpected report", int'(a), 0);
      end else begin
        rpt_t e;
        e = exp_q.pop_front();
        chk(a == e, "R5/R6/R7/R8/R11/R12 report", int'(a), int'(e));
      end
    end
  end

  task automatic send_req(input logic [7:0] c, input logic [3:0] l,
                          input logic [NPAY*8-1:0] p, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_len = l; req_payload = p; req_want_reply = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic step(input logic s, input logic [7:0] rx);
    @(negedge clk);
    byte_done = 1'b1; xcvr_stat_n = s; sh_rx_byte = rx;
    @(negedge clk);
    byte_done = 1'b0; xcvr_stat_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic chk_bus(input logic [1:0] st, input logic oe, input string tag);
    chk(bus_state == st, {tag, " state"}, bus_state, st);
    chk(sh_out_en == oe, {tag, " dir"}, sh_out_en, oe);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_len = '0; req_payload = '0;
    req_want_reply = 1'b0; byte_done = 1'b0; xcvr_stat_n = 1'b1; sh_rx_byte = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bus(2'b11, 1'b0, "R1 reset");
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(done == 1'b0, "R1 done", done, 0);

    // R12: bad lengths
    expect_rpt(1, 0, 0, 0, 0);
    send_req(8'h2B, 4'd0, '0, 1'b0);
    chk_bus(2'b11, 1'b0, "R12 len0");
    expect_rpt(1, 0, 0, 0, 0);
    send_req(8'h2B, 4'd14, '0, 1'b0);
    chk_bus(2'b11, 1'b0, "R12 len14");
    chk(req_ready == 1'b1, "R12 ready", req_ready, 1);

    // R2/R3/R5: plain write of two bytes
    send_req(8'h2B, 4'd2, {88'h0, 8'h22, 8'h11}, 1'b0);
    chk_bus(2'b00, 1'b1, "R2 start");
    chk(sh_tx_byte == 8'h2B, "R2 cmd byte", sh_tx_byte, 8'h2B);
    chk(sh_load == 1'b1, "R2 load", sh_load, 1);
    step(1, 8'h00);
    chk_bus(2'b01, 1'b1, "R3 first");
    chk(sh_tx_byte == 8'h11, "R3 byte0", sh_tx_byte, 8'h11);
    step(1, 8'h00);
    chk_bus(2'b10, 1'b1, "R3 second");
    chk(sh_tx_byte == 8'h22, "R3 byte1", sh_tx_byte, 8'h22);
    expect_rpt(0, 0, 0, 0, 0);
    step(1, 8'h00);
    chk_bus(2'b11, 1'b0, "R5 no reply idle");
    chk(req_ready == 1'b1, "R1 ready again", req_ready, 1);

    // R5/R8: reply wanted
    send_req(8'h21, 4'd1, {96'h0, 8'h55}, 1'b1);
    step(1, 8'h00);
    chk(sh_tx_byte == 8'h55, "R3 payload", sh_tx_byte, 8'h55);
    step(1, 8'h00);
    chk_bus(2'b10, 1'b0, "R5 turnaround");
    step(1, 8'hA1);
    chk_bus(2'b01, 1'b0, "R8 rx1");
    step(1, 8'hA2);
    expect_rpt(0, 0, 0, 0, 3);
    step(0, 8'h00);
    chk_bus(2'b11, 1'b0, "R8 end");
    rd(4'd0, v); chk(v == 8'h21, "R5 byte0 cmd", v, 8'h21);
    rd(4'd2, v); chk(v == 8'hA2, "R8 byte2", v, 8'hA2);

    // R5/R6/R7: talk without reply flag, timeout and service request
    send_req(8'h3C, 4'd2, {88'h0, 8'h02, 8'h01}, 1'b0);
    step(1, 8'h00);
    step(1, 8'h00);
    expect_rpt(0, 0, 0, 0, 0);
    step(1, 8'h00);
    chk_bus(2'b01, 1'b0, "R5 talk read");
    step(0, 8'hD1);
    chk_bus(2'b10, 1'b0, "R6 timeout keeps going");
    step(0, 8'hD2);
    chk_bus(2'b01, 1'b0, "R7 srq keeps going");
    expect_rpt(0, 1, 1, 1, 0);
    step(0, 8'h00);
    chk_bus(2'b11, 1'b0, "R6 end idle");

    // R4: buffered reply in command state, then resend
    send_req(8'h2B, 4'd1, {96'h0, 8'h77}, 1'b0);
    step(0, 8'h99);
    chk_bus(2'b01, 1'b0, "R4 switch in");
    chk(req_ready == 1'b0, "R4 not ready", req_ready, 0);
    step(1, 8'hB1);
    step(1, 8'hB2);
    expect_rpt(0, 1, 0, 0, 3);
    step(0, 8'h00);
    chk_bus(2'b00, 1'b1, "R4 resend");
    chk(sh_tx_byte == 8'h2B, "R4 resend cmd", sh_tx_byte, 8'h2B);
    rd(4'd0, v); chk(v == 8'h3C, "R4 byte0 last talk", v, 8'h3C);
    rd(4'd1, v); chk(v == 8'hB1, "R4 byte1", v, 8'hB1);
    step(1, 8'h00);
    chk(sh_tx_byte == 8'h77, "R4 payload", sh_tx_byte, 8'h77);
    expect_rpt(0, 0, 0, 0, 0);
    step(1, 8'h00);
    chk_bus(2'b11, 1'b0, "R1 after resend");

    // R10: unsolicited in idle
    step(0, 8'hC1);
    chk_bus(2'b01, 1'b0, "R10 even");
    step(1, 8'hC2);
    step(1, 8'hC3);
    expect_rpt(0, 1, 0, 0, 3);
    step(0, 8'h00);
    rd(4'd0, v); chk(v == 8'hC1, "R10 byte0", v, 8'hC1);
    rd(4'd2, v); chk(v == 8'hC3, "R10 byte2", v, 8'hC3);

    // R11: idle with status high
    expect_rpt(0, 1, 1, 0, 0);
    step(1, 8'h00);
    chk_bus(2'b11, 1'b0, "R11 stays idle");

    // R9: overflow
    send_req(8'h21, 4'd2, {88'h0, 8'h02, 8'h01}, 1'b1);
    step(1, 8'h00);
    step(1, 8'h00);
    step(1, 8'h00);
    chk_bus(2'b01, 1'b0, "R9 read start");
    for (int i = 0; i < 20; i++) step(1, 8'(8'h40 + i));
    chk_bus(2'b01, 1'b0, "R9 toggles past full");
    expect_rpt(0, 0, 0, 0, 16);
    step(0, 8'h00);
    rd(4'd15, v); chk(v == 8'h4E, "R9 last kept", v, 8'h4E);
    rd(4'd1, v); chk(v == 8'h40, "R9 first rx", v, 8'h40);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing reports", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule